// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional-trap instruction should fire. It receives two operands, a five-bit condition mask and a width select, compares the operands as signed and as unsigned numbers at the same time, and raises a trap request when at least one relation that the mask enables is true. When the request is raised it also carries a fixed sub-cause code. Execution logic uses that code to mark the resulting program exception as a trap.

The comparison itself is combinational. The result is captured in a register, so the answer appears one clock after the operands, together with a one-cycle valid strobe. In word mode only the low half of each operand is compared. In doubleword mode the full operand width is compared. The block does not decode instructions, flush the pipeline or deliver the exception.

Top module: `trap_cond_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when op_a is less than op_b as two's-complement signed numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when op_a is greater than op_b as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when op_a equals op_b.
- R4: Mask bit 1 (value 0x02) enables a trap when op_a is less than op_b as unsigned numbers.
- R5: Mask bit 0 (value 0x01) enables a trap when op_a is greater than op_b as unsigned numbers.
- R6: The trap request is the OR of every enabled relation. Signed and unsigned relations are evaluated in parallel on the same operands.
- R7: With dword_mode low (word mode), only bits 31:0 of each operand take part, read as 32-bit signed or unsigned values. Bits 63:32 have no effect on the result.
- R8: With dword_mode high, all 64 bits of each operand take part.
- R9: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R10: out_valid is high exactly in the cycle after a cycle in which in_valid was high. trap_req is high only together with out_valid.
- R11: trap_cause is 4'h4 when trap_req is high and 4'h0 otherwise.
- R12: While rst_n is low at a clock edge, out_valid, trap_req and trap_cause are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| dword_mode | input | 1 | 1: compare 64 bits, 0: compare low 32 bits |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_mask | input | 5 | Relation enables: bit4 signed less, bit3 signed greater, bit2 equal, bit1 unsigned less, bit0 unsigned greater |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| trap_req | output | 1 | Trap condition met |
| trap_cause | output | 4 | Program-exception sub-cause, 4'h4 on a trap, 0 otherwise |

## Verification
A signed relation and an unsigned relation can both be enabled in the same cycle, and they can disagree. For example, op_a = -1 and op_b = 1 is signed-less and unsigned-greater at the same time. The bench provokes this with directed pairs that straddle the sign bit and with masks that enable only one type of relation or both. The expected request is computed separately for each relation and ORed in the bench. Word-mode compare and upper-half garbage also meet in one cycle: the bench fills bits 63:32 with random values that would reverse a 64-bit result, and judges the outcome on the low halves alone.

// File: rtl/trapcmp_pkg.sv
// Shared definitions for the conditional trap compare unit.
// The packed relation struct lists fields in the same order as the
// condition mask bits (MSB signed-less ... LSB unsigned-greater), so a
// relation vector can be ANDed with the mask bit for bit.
package trapcmp_pkg;
    localparam int MASK_W  = 5;
    localparam int CAUSE_W = 4;

    typedef struct packed {
        logic slt;   // mask bit 4
        logic sgt;   // mask bit 3
        logic eq;    // mask bit 2
        logic ult;   // mask bit 1
        logic ugt;   // mask bit 0
    } rel_t;
endpackage

// File: rtl/tc_operand_prep.sv
// Operand preparation: forms the signed-view and unsigned-view operands.
// In narrow mode the low WLEN bits are sign-extended (signed view) or
// zero-extended (unsigned view) to XLEN, so the upper bits cannot affect
// any relation. Assumes XLEN >= WLEN.
module tc_operand_prep #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic            wide_sel,
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    output logic [XLEN-1:0] a_sv,
    output logic [XLEN-1:0] b_sv,
    output logic [XLEN-1:0] a_uv,
    output logic [XLEN-1:0] b_uv
);
    localparam int EXT_W = XLEN - WLEN;

    generate
        if (EXT_W > 0) begin : g_ext
            logic [XLEN-1:0] a_sx, b_sx, a_zx, b_zx;
            // Extend the narrow operands both ways
            always_comb begin
                a_sx = {{EXT_W{a_in[WLEN-1]}}, a_in[WLEN-1:0]};
                b_sx = {{EXT_W{b_in[WLEN-1]}}, b_in[WLEN-1:0]};
                a_zx = {{EXT_W{1'b0}}, a_in[WLEN-1:0]};
                b_zx = {{EXT_W{1'b0}}, b_in[WLEN-1:0]};
            end
            // Select full-width or narrow-extended views
            always_comb begin
                a_sv = wide_sel ? a_in : a_sx;
                b_sv = wide_sel ? b_in : b_sx;
                a_uv = wide_sel ? a_in : a_zx;
                b_uv = wide_sel ? b_in : b_zx;
            end
        end else begin : g_same
            // Widths equal: both modes see the whole operand
            always_comb begin
                a_sv = a_in;
                b_sv = b_in;
                a_uv = a_in;
                b_uv = b_in;
            end
        end
    endgenerate
endmodule

// File: rtl/tc_relations.sv
// Relation evaluator: computes signed and unsigned orderings and equality
// in parallel. Equality is taken on the unsigned view; both views agree on
// equality, since extension preserves it.
module tc_relations
    import trapcmp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_sv,
    input  logic [XLEN-1:0] b_sv,
    input  logic [XLEN-1:0] a_uv,
    input  logic [XLEN-1:0] b_uv,
    output rel_t            rel
);
    // Evaluate all five relations concurrently
    always_comb begin
        rel.slt = $signed(a_sv) < $signed(b_sv);
        rel.sgt = $signed(a_sv) > $signed(b_sv);
        rel.eq  = a_uv == b_uv;
        rel.ult = a_uv < b_uv;
        rel.ugt = a_uv > b_uv;
    end
endmodule

// File: rtl/tc_mask_merge.sv
// Mask merge: gates each relation with its mask bit and ORs the results.
// Assumes the rel_t field order matches the mask bit order.
module tc_mask_merge
    import trapcmp_pkg::*;
(
    input  rel_t              rel,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [MASK_W-1:0] rel_bits;
    logic [MASK_W-1:0] gated;

    assign rel_bits = rel;

    generate
        for (genvar i = 0; i < MASK_W; i++) begin : g_gate
            // Enable one relation by its mask bit
            assign gated[i] = rel_bits[i] & mask[i];
        end
    endgenerate

    // Any enabled relation that holds raises the hit
    assign hit = |gated;
endmodule

// File: rtl/trap_cond_unit.sv
// Conditional trap compare unit (top). Combinational compare of two
// operands under a five-bit relation mask, registered into a one-cycle
// result strobe with trap request and fixed sub-cause code.
// Assumes inputs are stable around the rising edge of clk; reset is
// synchronous and active low.
module trap_cond_unit
    import trapcmp_pkg::*;
#(
    parameter int                  XLEN       = 64,
    parameter int                  WLEN       = 32,
    parameter logic [CAUSE_W-1:0]  TRAP_CAUSE = 4'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               dword_mode,
    input  logic [XLEN-1:0]    op_a,
    input  logic [XLEN-1:0]    op_b,
    input  logic [MASK_W-1:0]  cond_mask,
    output logic               out_valid,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause
);
    logic [XLEN-1:0] a_sv, b_sv, a_uv, b_uv;
    rel_t            rel;
    logic            hit;
    logic            fire;

    tc_operand_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
        .wide_sel (dword_mode),
        .a_in     (op_a),
        .b_in     (op_b),
        .a_sv     (a_sv),
        .b_sv     (b_sv),
        .a_uv     (a_uv),
        .b_uv     (b_uv)
    );

    tc_relations #(.XLEN(XLEN)) u_rel (
        .a_sv (a_sv),
        .b_sv (b_sv),
        .a_uv (a_uv),
        .b_uv (b_uv),
        .rel  (rel)
    );

    tc_mask_merge u_merge (
        .rel  (rel),
        .mask (cond_mask),
        .hit  (hit)
    );

    // A trap is only requested for a valid input
    assign fire = in_valid & hit;

    // Register the strobe, request and sub-cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            trap_req   <= 1'b0;
            trap_cause <= '0;
        end else begin
            out_valid  <= in_valid;
            trap_req   <= fire;
            trap_cause <= fire ? TRAP_CAUSE : '0;
        end
    end
endmodule

// File: rtl/tc_checker.sv
// Checker for trap_cond_unit: port-level temporal properties.
// Attached to every trap_cond_unit instance by the bind below.
module tc_checker #(
    parameter int XLEN    = 64,
    parameter int MASK_W  = 5,
    parameter int CAUSE_W = 4,
    parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 4'h4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               dword_mode,
    input logic [XLEN-1:0]    op_a,
    input logic [XLEN-1:0]    op_b,
    input logic [MASK_W-1:0]  cond_mask,
    input logic               out_valid,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R10
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R10
    AST_REQ_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> out_valid);  // R10
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '0) |=> !trap_req);  // R9
    AST_FULL_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '1) |=> trap_req);  // R9
    AST_EQ_WORD_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dword_mode && cond_mask[2] && op_a[31:0] == op_b[31:0])
        |=> trap_req);  // R3
    AST_EQ_DWORD_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dword_mode && cond_mask[2] && op_a == op_b)
        |=> trap_req);  // R8
    AST_CAUSE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_cause == TRAP_CAUSE);  // R11
    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_cause == '0);  // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !trap_req));  // R12
endmodule

bind trap_cond_unit tc_checker #(
    .XLEN(XLEN), .MASK_W(trapcmp_pkg::MASK_W),
    .CAUSE_W(trapcmp_pkg::CAUSE_W), .TRAP_CAUSE(TRAP_CAUSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dword_mode(dword_mode),
    .op_a(op_a), .op_b(op_b), .cond_mask(cond_mask), .out_valid(out_valid),
    .trap_req(trap_req), .trap_cause(trap_cause)
);

// File: tb/sim_trap_cond_unit.sv
// Self-checking bench: directed corner cases plus seeded random vectors.
module sim_trap_cond_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        dword_mode;
    logic [63:0] op_a, op_b;
    logic [4:0]  cond_mask;
    logic        out_valid, trap_req;
    logic [3:0]  trap_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_cond_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dword_mode(dword_mode),
        .op_a(op_a), .op_b(op_b), .cond_mask(cond_mask),
        .out_valid(out_valid), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    // Expected request computed from the relation definitions
    function automatic logic want_trap(logic dw, logic [63:0] a, logic [63:0] b,
                                       logic [4:0] m);
        logic [63:0] ua, ub;
        logic signed [63:0] sa, sb;
        if (dw) begin
            ua = a; ub = b; sa = a; sb = b;
        end else begin
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
            sa = {{32{a[31]}}, a[31:0]};
            sb = {{32{b[31]}}, b[31:0]};
        end
        return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
               (m[1] && ua < ub) || (m[0] && ua > ub);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one vector, wait for the registered result, then check it
    task automatic run_vec(string req, logic dw, logic [63:0] a, logic [63:0] b,
                           logic [4:0] m);
        logic e;
        e = want_trap(dw, a, b, m);
        @(negedge clk);
        in_valid = 1'b1; dword_mode = dw; op_a = a; op_b = b; cond_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, out_valid, 1);
        check({req, " trap"}, trap_req, e);
        check({req, " cause"}, trap_cause, e ? 4'h4 : 4'h0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] ra, rb;
        logic [4:0]  rm;
        logic        rd, e_prev;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; in_valid = 1'b0; dword_mode = 1'b0;
        op_a = '0; op_b = '0; cond_mask = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 out_valid", out_valid, 0);
        check("R12 trap_req", trap_req, 0);
        check("R12 trap_cause", trap_cause, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R10 idle: no strobe without input valid
        check("R10 idle valid", out_valid, 0);

        // R1/R5 single relation checks with sign-straddling operands
        run_vec("R1", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h10);   // -1 < 1 signed
        run_vec("R1", 1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h10);
        run_vec("R2", 1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08);
        run_vec("R3", 1, 64'h1234, 64'h1234, 5'h04);
        run_vec("R3", 1, 64'h1234, 64'h1235, 5'h04);
        run_vec("R4", 1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02);
        run_vec("R5", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01);
        run_vec("R5", 1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h01);
        // R6 signed and unsigned disagree, both enabled
        run_vec("R6", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h12);
        run_vec("R6", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h0A);
        // R7 word mode ignores upper halves
        run_vec("R7", 0, 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0001, 5'h10);
        run_vec("R7", 0, 64'hDEAD_BEEF_0000_0005, 64'h0123_4567_0000_0005, 5'h04);
        run_vec("R7", 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 5'h09);
        // R8 doubleword mode sees upper halves
        run_vec("R8", 1, 64'hDEAD_BEEF_0000_0005, 64'h0123_4567_0000_0005, 5'h04);
        run_vec("R8", 1, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 5'h01);
        // R9 mask extremes
        run_vec("R9", 1, 64'h5, 64'h9, 5'h00);
        run_vec("R9", 0, 64'h5, 64'h5, 5'h1F);
        run_vec("R9", 1, 64'h8000_0000_0000_0000, 64'h7, 5'h1F);

        // R6/R11 random back-to-back stream, mixed operand shapes
        e_prev = 1'b0;
        for (int i = 0; i < 600; i++) begin
            rd = $urandom() % 2;
            ra = {$urandom(), $urandom()};
            case ($urandom() % 4)
                0: rb = ra;
                1: rb = ra + 64'h1;
                2: rb = {$urandom(), ra[31:0]};
                default: rb = {$urandom(), $urandom()};
            endcase
            rm = 5'($urandom());
            @(negedge clk);
            if (i > 0) begin
                check("R6 stream trap", trap_req, e_prev);
                check("R11 stream cause", trap_cause, e_prev ? 4'h4 : 4'h0);
                check("R10 stream valid", out_valid, 1);
            end
            in_valid = 1'b1; dword_mode = rd; op_a = ra; op_b = rb; cond_mask = rm;
            e_prev = want_trap(rd, ra, rb, rm);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 stream last", trap_req, e_prev);
        @(negedge clk);
        check("R10 strobe drops", out_valid, 0);
        check("R11 idle cause", trap_cause, 0);

        // R12 reset in mid-stream clears a pending trap
        @(negedge clk);
        in_valid = 1'b1; dword_mode = 1'b1; op_a = 64'h3; op_b = 64'h3; cond_mask = 5'h1F;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 mid trap", trap_req, 0);
        check("R12 mid valid", out_valid, 0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule